// File: doc/BRIEF.md
# Sequenced Status Packet Generator

This block reports a status word to a downstream collector as a short byte-serial packet. A single configuration write sets a 6-bit sequence tag and a reporting mode. When the block has something to report, it raises a request. While the request is high, the output shows the block's own register address. The collector answers with a start pulse. The block then drops the request and puts the payload on the byte output, one byte per clock. The first payload byte carries the sequence tag together with the two lowest status bits. The following bytes carry the rest of the status word, eight bits at a time.

Four reporting modes exist: silent, one packet only, automatic reporting whenever the status differs from the last value sent, and automatic reporting combined with one immediate packet. The payload width and the register address are parameters. The packet length follows from the payload width. Arbitration among several reporters and the receiving side belong elsewhere.

Top module: `status_packet_gen`

## Requirements
- R1: After synchronous reset, `statusRq` is low, `statusAd` is zero, the mode is silent and the sequence tag is zero.
- R2: A write with `cfgWe` high loads `cfgData[7:2]` as the sequence tag. `cfgData[1:0]` selects the mode: 0 silent, 1 one packet, 2 automatic, 3 automatic plus one immediate packet.
- R3: In one-packet mode, `statusRq` rises on the clock after the write edge. After that packet is accepted, the mode returns to silent, so a later status change raises no request.
- R4: While `statusRq` is high, `statusAd` equals the parameter `REG_ADDR` (default 0x3A). The request stays high until it is accepted or cancelled.
- R5: When `statusStart` is high at an edge where `statusRq` is high, `statusRq` falls at that edge. From that edge on, consecutive clocks show `{tag[5:0], status[1:0]}`, then `status[9:2]`, then `status[17:10]` and so on. The status used is the value sampled at the accepting edge.
- R6: The packet has `1 + ceil((PAYLOAD_BITS-2)/8)` payload bytes (two for the default of 9 bits). Status bits above `PAYLOAD_BITS-1` in the last byte are sent as zero. `statusAd` is zero when neither a request nor a packet is active.
- R7: In automatic mode, a status that differs from the last value sent raises `statusRq` at the next edge. A status equal to the last value sent raises nothing.
- R8: Mode 3 raises a request even when the status is unchanged. Afterwards the block keeps reporting changes automatically.
- R9: A write selecting mode 0 clears a pending request at that edge, unless the request is accepted at the same edge. No further requests follow.
- R10: No new request rises while payload bytes are still being sent. A change that arrives during a packet is requested on the first idle clock after the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 8 | Configuration byte: tag in [7:2], mode in [1:0] |
| status | input | PAYLOAD_BITS | Status word to report |
| statusAd | output | 8 | Byte output: address while requesting, then payload |
| statusRq | output | 1 | Request to send a packet |
| statusStart | input | 1 | Acceptance of the address byte |

## Verification
The assertions check these rules on every cycle:
- The address is shown whenever the request is high.
- The request falls on acceptance, and the first payload byte carries the accepted low status bits.
- A write selecting mode 0 drops the request.
- The request never overlaps an active packet.
- The output is zero when the block is quiet.

Only the directed scenarios can show the following:
- The full byte sequence and its zero fill.
- The single-mode return to silence.
- Suppression of a report when the status equals the last value sent.
- Mode 3 forcing a packet without a change.
- A change that arrives mid-packet being deferred until the packet ends.

// File: rtl/statpkt_pkg.sv
package statpkt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ONCE = 2'd1,
    MODE_AUTO = 2'd2
  } reportMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // take a snapshot of status and tag
    logic showAddr;   // drive the register address
    logic inPayload;  // drive a payload byte
  } dpStrobe_t;

endpackage

// File: rtl/status_packet_ctrl.sv
module status_packet_ctrl
  import statpkt_pkg::*;
#(
  parameter int NUM_PAY = 2,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWe,
  input  logic [7:0]       cfgData,
  input  logic             changed,
  input  logic             statusStart,
  output logic             statusRq,
  output logic [5:0]       seqNum,
  output dpStrobe_t        strobe,
  output logic [CNT_W-1:0] byteIdx
);

  reportMode_e      mode;
  logic             pendOnce;
  logic [CNT_W-1:0] byteCnt;
  logic             accept;
  logic             idle;
  logic             wantSend;
  logic             cfgOff;

  assign accept   = statusRq & statusStart;
  assign idle     = (byteCnt == '0);
  assign wantSend = idle & ~statusRq & (pendOnce | ((mode == MODE_AUTO) & changed));
  assign cfgOff   = cfgWe & (cfgData[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_OFF;
      seqNum   <= '0;
      pendOnce <= 1'b0;
      statusRq <= 1'b0;
      byteCnt  <= '0;
    end else begin
      if (accept) begin
        statusRq <= 1'b0;
        byteCnt  <= CNT_W'(1);
        pendOnce <= 1'b0;
        if (mode == MODE_ONCE) mode <= MODE_OFF;
      end else if (!idle) begin
        byteCnt <= (byteCnt == CNT_W'(NUM_PAY)) ? '0 : byteCnt + 1'b1;
      end else if (wantSend) begin
        statusRq <= 1'b1;
      end

      if (cfgWe) begin
        seqNum <= cfgData[7:2];
        case (cfgData[1:0])
          2'b00: begin mode <= MODE_OFF;  pendOnce <= 1'b0; end
          2'b01: begin mode <= MODE_ONCE; pendOnce <= 1'b1; end
          2'b10: begin mode <= MODE_AUTO; pendOnce <= 1'b0; end
          default: begin mode <= MODE_AUTO; pendOnce <= 1'b1; end
        endcase
        if (cfgOff && !accept) statusRq <= 1'b0;
      end
    end
  end

  assign strobe.capture   = accept;
  assign strobe.showAddr  = statusRq;
  assign strobe.inPayload = ~idle;
  assign byteIdx          = byteCnt - 1'b1;

endmodule

// File: rtl/status_packet_dp.sv
module status_packet_dp
  import statpkt_pkg::*;
#(
  parameter int           PAYLOAD_BITS = 9,
  parameter logic [7:0]   REG_ADDR     = 8'h3A,
  parameter int           NUM_PAY      = 2,
  parameter int           CNT_W        = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PAYLOAD_BITS-1:0] status,
  input  logic [5:0]              seqNum,
  input  dpStrobe_t               strobe,
  input  logic [CNT_W-1:0]        byteIdx,
  output logic                    changed,
  output logic [7:0]              statusAd
);

  localparam int PAD_W = 8 * NUM_PAY - 6;

  // the snapshot doubles as the last value sent
  logic [PAYLOAD_BITS-1:0] sentStatus;
  logic [5:0]              sentSeq;
  logic [PAD_W-1:0]        padded;
  logic [7:0]              payByte [NUM_PAY];

  always_ff @(posedge clk) begin
    if (rst) begin
      sentStatus <= '0;
      sentSeq    <= '0;
    end else if (strobe.capture) begin
      sentStatus <= status;
      sentSeq    <= seqNum;
    end
  end

  assign changed    = (status != sentStatus);
  assign padded     = PAD_W'(sentStatus);
  assign payByte[0] = {sentSeq, padded[1:0]};

  for (genvar i = 1; i < NUM_PAY; i++) begin : g_byte
    assign payByte[i] = padded[8*i-6 +: 8];
  end

  always_comb begin
    statusAd = '0;
    if (strobe.showAddr) begin
      statusAd = REG_ADDR;
    end else if (strobe.inPayload) begin
      for (int i = 0; i < NUM_PAY; i++) begin
        if (byteIdx == CNT_W'(i)) statusAd = payByte[i];
      end
    end
  end

endmodule

// File: rtl/status_packet_gen.sv
module status_packet_gen
  import statpkt_pkg::*;
#(
  parameter int         PAYLOAD_BITS = 9,
  parameter logic [7:0] REG_ADDR     = 8'h3A
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfgWe,
  input  logic [7:0]              cfgData,
  input  logic [PAYLOAD_BITS-1:0] status,
  output logic [7:0]              statusAd,
  output logic                    statusRq,
  input  logic                    statusStart
);

  localparam int NUM_PAY = 1 + (PAYLOAD_BITS - 2 + 7) / 8;
  localparam int CNT_W   = $clog2(NUM_PAY + 1);

  dpStrobe_t        strobe;
  logic [5:0]       seqNum;
  logic [CNT_W-1:0] byteIdx;
  logic             changed;

  status_packet_ctrl #(
    .NUM_PAY (NUM_PAY),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cfgWe       (cfgWe),
    .cfgData     (cfgData),
    .changed     (changed),
    .statusStart (statusStart),
    .statusRq    (statusRq),
    .seqNum      (seqNum),
    .strobe      (strobe),
    .byteIdx     (byteIdx)
  );

  status_packet_dp #(
    .PAYLOAD_BITS (PAYLOAD_BITS),
    .REG_ADDR     (REG_ADDR),
    .NUM_PAY      (NUM_PAY),
    .CNT_W        (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .status   (status),
    .seqNum   (seqNum),
    .strobe   (strobe),
    .byteIdx  (byteIdx),
    .changed  (changed),
    .statusAd (statusAd)
  );

endmodule

// File: rtl/status_packet_chk.sv
module status_packet_chk
  import statpkt_pkg::*;
#(
  parameter int         PAYLOAD_BITS = 9,
  parameter logic [7:0] REG_ADDR     = 8'h3A
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfgWe,
  input logic [7:0]              cfgData,
  input logic [PAYLOAD_BITS-1:0] status,
  input logic [7:0]              statusAd,
  input logic                    statusRq,
  input logic                    statusStart,
  input dpStrobe_t               strobe
);

  p_addr_shown_r4: assert property (@(posedge clk) disable iff (rst)
    statusRq |-> statusAd == REG_ADDR);

  p_rq_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (statusRq && !statusStart && !cfgWe) |=> statusRq);

  p_rq_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (statusRq && statusStart) |=> !statusRq);

  p_first_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (statusRq && statusStart) |=> statusAd[1:0] == $past(status[1:0]));

  p_quiet_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!statusRq && !strobe.inPayload) |-> statusAd == 8'h00);

  p_off_cancel_r9: assert property (@(posedge clk) disable iff (rst)
    (cfgWe && cfgData[1:0] == 2'b00 && !(statusRq && statusStart)) |=> !statusRq);

  p_busy_no_rq_r10: assert property (@(posedge clk) disable iff (rst)
    strobe.inPayload |-> !statusRq);

endmodule

bind status_packet_gen status_packet_chk #(
  .PAYLOAD_BITS (PAYLOAD_BITS),
  .REG_ADDR     (REG_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfgWe       (cfgWe),
  .cfgData     (cfgData),
  .status      (status),
  .statusAd    (statusAd),
  .statusRq    (statusRq),
  .statusStart (statusStart),
  .strobe      (strobe)
);

// File: tb/status_packet_gen_tb.sv
module status_packet_gen_tb;

  localparam int         PB   = 9;
  localparam logic [7:0] ADDR = 8'h3A;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfgWe;
  logic [7:0]    cfgData;
  logic [PB-1:0] status;
  logic [7:0]    statusAd;
  logic          statusRq;
  logic          statusStart;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  status_packet_gen #(.PAYLOAD_BITS(PB), .REG_ADDR(ADDR)) u_dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgData(cfgData), .status(status),
    .statusAd(statusAd), .statusRq(statusRq), .statusStart(statusStart)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // status bits 9:2 of a 9-bit word, top bit zero-filled
  function automatic logic [7:0] hiByte(input logic [PB-1:0] s);
    return {1'b0, s[8:2]};
  endfunction

  task automatic cfgWrite(input logic [7:0] d);
    cfgWe = 1'b1; cfgData = d;
    step();
    cfgWe = 1'b0; cfgData = '0;
  endtask

  // accept a request and check both payload bytes and the return to idle
  task automatic acceptAndCheck(input string req, input logic [5:0] tag, input logic [PB-1:0] s);
    statusStart = 1'b1;
    step();
    statusStart = 1'b0;
    chk({req, " rq drop"}, {7'b0, statusRq}, 8'h00);
    chk({req, " byte1"}, statusAd, {tag, s[1:0]});
    step();
    chk({req, " byte2"}, statusAd, hiByte(s));
    step();
    chk({req, " idle zero R6"}, statusAd, 8'h00);
  endtask

  task automatic tReset();
    rst = 1'b1; cfgWe = 1'b0; cfgData = '0; status = '0; statusStart = 1'b0;
    step(); step();
    rst = 1'b0;
    step();
    chk("R1 rq", {7'b0, statusRq}, 8'h00);
    chk("R1 ad", statusAd, 8'h00);
    step();
    chk("R1 silent", {7'b0, statusRq}, 8'h00);
  endtask

  task automatic tSingle();
    status = 9'h1A5;
    cfgWrite({6'h2B, 2'b01});
    chk("R3 not yet", {7'b0, statusRq}, 8'h00);
    step();
    chk("R3 rq", {7'b0, statusRq}, 8'h01);
    chk("R4 addr", statusAd, ADDR);
    step();
    chk("R4 hold", {7'b0, statusRq}, 8'h01);
    acceptAndCheck("R5 R2 single", 6'h2B, 9'h1A5);
    status = 9'h0FF;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 back to off", {7'b0, statusRq}, 8'h00);
    end
  endtask

  task automatic tZeroFill();
    status = 9'h1FF;
    cfgWrite({6'h00, 2'b01});
    step();
    chk("R6 rq", {7'b0, statusRq}, 8'h01);
    acceptAndCheck("R6 zero fill", 6'h00, 9'h1FF);
    chk("R6 fill value", hiByte(9'h1FF), 8'h7F);
  endtask

  task automatic tAuto();
    status = 9'h1FF;  // equals last sent
    cfgWrite({6'h03, 2'b10});
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R7 unchanged silent", {7'b0, statusRq}, 8'h00);
    end
    status = 9'h1A4;
    step();
    chk("R7 change rq", {7'b0, statusRq}, 8'h01);
    statusStart = 1'b1;
    step();
    statusStart = 1'b0;
    chk("R5 auto byte1", statusAd, {6'h03, 2'b00});
    status = 9'h0F0;  // change during packet
    step();
    chk("R10 byte2", statusAd, hiByte(9'h1A4));
    chk("R10 no rq busy", {7'b0, statusRq}, 8'h00);
    step();
    chk("R10 no rq last", {7'b0, statusRq}, 8'h00);
    step();
    chk("R10 deferred rq", {7'b0, statusRq}, 8'h01);
    acceptAndCheck("R7 second", 6'h03, 9'h0F0);
    step();
    chk("R7 no repeat", {7'b0, statusRq}, 8'h00);
  endtask

  task automatic tOnceNow();
    cfgWrite({6'h3F, 2'b11});
    chk("R8 not yet", {7'b0, statusRq}, 8'h00);
    step();
    chk("R8 forced rq", {7'b0, statusRq}, 8'h01);
    acceptAndCheck("R8 packet", 6'h3F, 9'h0F0);
    step(); step();
    chk("R8 then quiet", {7'b0, statusRq}, 8'h00);
    status = 9'h001;
    step();
    chk("R8 stays auto", {7'b0, statusRq}, 8'h01);
  endtask

  task automatic tCancel();
    cfgWrite({6'h11, 2'b00});
    chk("R9 cancel rq", {7'b0, statusRq}, 8'h00);
    chk("R9 cancel ad", statusAd, 8'h00);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R9 stays off", {7'b0, statusRq}, 8'h00);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tReset();
    tSingle();
    tZeroFill();
    tAuto();
    tOnceNow();
    tCancel();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule